// File: doc/BRIEF.md
# Multiplexed Pseudo-Static RAM Bus Controller

This block sits between a synchronous host and an asynchronous pseudo-static RAM that shares one 16-bit bus between address and data. The host posts one request at a time: a 21-bit word address, write data, two byte-lane enables and a read/write flag, qualified by a valid/ready handshake. Reads come back as a data word with a one-cycle valid strobe.

Each access runs as a fixed sequence of phases. First comes an address phase: chip select and the address strobe go low, the low address half is driven onto the shared bus and the upper address bits onto their own pins. A hold phase follows with the strobe high and the address still driven. Then comes a data phase. For a read, output enable is low and the bus is released. For a write, write enable is low and the write data is driven. The access ends with a recovery phase with chip select high. The length of every phase is a parameter counted in clock cycles. Elaboration checks that these counts, multiplied by the clock period parameter, meet the device's nanosecond minimums and its write-pulse maximum. After reset the controller keeps chip select high for a power-up window before it takes the first request.

Top module: `psram_mux_ctrl`

## Requirements
- R1: From reset, chip select, address strobe, output enable, write enable and both byte selects are high, the bus driver is off, and `req_ready` stays low for exactly `PWRUP_CYC` cycles before it first rises.
- R2: The address phase lasts `ADDR_CYC` cycles. In it chip select and the address strobe are low together, the bus driver is on with `req_addr[15:0]`, and `psram_ahi` carries `req_addr[20:16]`.
- R3: After the address strobe rises, the address stays driven on the bus for `GAP_CYC` cycles before output enable or write enable falls.
- R4: A read holds output enable low for `RD_CYC` cycles. Throughout that time the bus driver is off and write enable is high.
- R5: Read data is sampled in the last output-enable-low cycle. It is returned with `rsp_valid` high for one cycle, in the first cycle after chip select rises. A lane whose enable was 0 returns zero.
- R6: A write holds write enable low for `WR_CYC` cycles and never longer. The bus carries the write data the whole time, and write enable and chip select rise together.
- R7: `psram_bsel_n[1]` (bits 15:8) and `psram_bsel_n[0]` (bits 7:0) are active-low copies of `req_be[1]` and `req_be[0]`. They are held constant while chip select is low and are high otherwise.
- R8: Between accesses chip select stays high for at least `REC_CYC` cycles. `req_ready` is high only when chip select is high and that recovery has passed.
- R9: Byte-lane writes change only the enabled lane, so a later word read returns the merged word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 1 = upper byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| psram_cs_n | output | 1 | Chip select, active low |
| psram_adv_n | output | 1 | Address latch strobe, active low |
| psram_oe_n | output | 1 | Output enable, active low |
| psram_we_n | output | 1 | Write enable, active low |
| psram_bsel_n | output | 2 | Byte selects, active low, bit 1 = upper |
| psram_ahi | output | 5 | Upper address bits |
| psram_dq_o | output | 16 | Shared bus drive value |
| psram_dq_oe | output | 1 | Shared bus drive enable |
| psram_dq_i | input | 16 | Shared bus sampled value |

## Verification
The assertions assume that the host holds its request fields steady while `req_valid` is high and does not depend on the block's behaviour on cycles when `req_ready` is low. They also assume that `psram_dq_i` is stable during the last output-enable-low cycle. The bench keeps within these limits. It raises `req_valid` for exactly one cycle, only on a cycle where ready was seen high. Its memory model drives the bus as a combinational function of the address it latched, so the sampled word never changes inside the output-enable window.

// File: rtl/psram_pkg.sv
package psram_pkg;

   typedef enum logic [2:0] {
      ST_PWRUP = 3'd0,
      ST_IDLE  = 3'd1,
      ST_ADDR  = 3'd2,
      ST_HOLD  = 3'd3,
      ST_READ  = 3'd4,
      ST_WRITE = 3'd5,
      ST_RECOV = 3'd6
   } psram_st_e;

   function automatic int unsigned max_of2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_dwell_cnt.sv
module psram_dwell_cnt #(
   parameter int unsigned W       = 8,
   parameter int unsigned RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= W'(RST_VAL);
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_phase_fsm.sv
module psram_phase_fsm
   import psram_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ADDR_CYC  = 1,
   parameter int unsigned GAP_CYC   = 1,
   parameter int unsigned RD_CYC    = 9,
   parameter int unsigned WR_CYC    = 7,
   parameter int unsigned REC_CYC   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             is_write,
   input  logic             dwell_done,
   output psram_st_e        state,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);
   localparam logic [CNT_W-1:0] L_ADDR = CNT_W'(ADDR_CYC - 1);
   localparam logic [CNT_W-1:0] L_GAP  = CNT_W'(GAP_CYC - 1);
   localparam logic [CNT_W-1:0] L_RD   = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] L_WR   = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] L_REC  = CNT_W'(REC_CYC - 1);

   psram_st_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      load_val = '0;
      unique case (st_q)
         ST_PWRUP: if (dwell_done) st_d = ST_IDLE;
         ST_IDLE:  if (fire) begin
                      st_d     = ST_ADDR;
                      load_val = L_ADDR;
                   end
         ST_ADDR:  if (dwell_done) begin
                      st_d     = ST_HOLD;
                      load_val = L_GAP;
                   end
         ST_HOLD:  if (dwell_done) begin
                      st_d     = is_write ? ST_WRITE : ST_READ;
                      load_val = is_write ? L_WR : L_RD;
                   end
         ST_READ,
         ST_WRITE: if (dwell_done) begin
                      st_d     = ST_RECOV;
                      load_val = L_REC;
                   end
         ST_RECOV: if (dwell_done) st_d = ST_IDLE;
         default:  st_d = ST_PWRUP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_PWRUP;
      else        st_q <= st_d;
   end

   assign load  = (st_d != st_q);
   assign state = st_q;
endmodule

// File: rtl/psram_lane_mask.sv
module psram_lane_mask #(
   parameter int unsigned LANES = 2
) (
   input  logic [LANES*8-1:0] din,
   input  logic [LANES-1:0]   lane_en,
   output logic [LANES*8-1:0] dout
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[g*8 +: 8] = lane_en[g] ? din[g*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/psram_mux_ctrl.sv
module psram_mux_ctrl
   import psram_pkg::*;
#(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CLK_NS    = 8,
   parameter int unsigned PWRUP_CYC = 18750,
   parameter int unsigned ADDR_CYC  = 1,
   parameter int unsigned GAP_CYC   = 1,
   parameter int unsigned RD_CYC    = 9,
   parameter int unsigned WR_CYC    = 7,
   parameter int unsigned REC_CYC   = 1,
   localparam int unsigned LANES    = DATA_W / 8,
   localparam int unsigned HI_W     = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              psram_cs_n,
   output logic              psram_adv_n,
   output logic              psram_oe_n,
   output logic              psram_we_n,
   output logic [LANES-1:0]  psram_bsel_n,
   output logic [HI_W-1:0]   psram_ahi,
   output logic [DATA_W-1:0] psram_dq_o,
   output logic              psram_dq_oe,
   input  logic [DATA_W-1:0] psram_dq_i
);
   // device limits in nanoseconds
   localparam int unsigned T_PWRUP_NS = 150000;
   localparam int unsigned T_ADDR_NS  = max_of2(7, 5);
   localparam int unsigned T_GAP_NS   = max_of2(5, 2);
   localparam int unsigned T_RDWIN_NS = 70;
   localparam int unsigned T_OE_NS    = 20;
   localparam int unsigned T_WP_NS    = 55;
   localparam int unsigned T_WPMAX_NS = 2500;
   localparam int unsigned T_REC_NS   = 5;
   localparam int unsigned MAX_LD     =
      max_of2(max_of2(PWRUP_CYC, max_of2(RD_CYC, WR_CYC)),
              max_of2(ADDR_CYC, max_of2(GAP_CYC, REC_CYC)));
   localparam int unsigned CNT_W      = $clog2(MAX_LD + 1);

   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_dw
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if (ADDR_W <= DATA_W) begin : g_bad_aw
      $error("ADDR_W must exceed DATA_W");
   end
   if (ADDR_CYC == 0 || GAP_CYC == 0 || RD_CYC == 0 || WR_CYC == 0 ||
       REC_CYC == 0 || PWRUP_CYC == 0) begin : g_bad_zero
      $error("every phase count must be at least one cycle");
   end
   if (PWRUP_CYC * CLK_NS < T_PWRUP_NS) begin : g_bad_pwr
      $error("power-up window too short");
   end
   if (ADDR_CYC * CLK_NS < T_ADDR_NS) begin : g_bad_addr
      $error("address phase too short for select and strobe setup");
   end
   if (GAP_CYC * CLK_NS < T_GAP_NS) begin : g_bad_gap
      $error("gap after strobe too short");
   end
   if (RD_CYC * CLK_NS < T_OE_NS ||
       (ADDR_CYC + GAP_CYC + RD_CYC) * CLK_NS < T_RDWIN_NS) begin : g_bad_rd
      $error("read window too short");
   end
   if (WR_CYC * CLK_NS < T_WP_NS || WR_CYC * CLK_NS > T_WPMAX_NS) begin : g_bad_wr
      $error("write pulse outside its limits");
   end
   if (REC_CYC * CLK_NS < T_REC_NS) begin : g_bad_rec
      $error("select recovery too short");
   end

   psram_st_e         state;
   logic              fire, dwell_done, load;
   logic [CNT_W-1:0]  load_val;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;
   logic              write_q;
   logic [DATA_W-1:0] rd_masked;
   logic              rd_last, active;

   assign req_ready = (state == ST_IDLE);
   assign fire      = req_valid & req_ready;

   psram_dwell_cnt #(.W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_dwell (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .done     (dwell_done)
   );

   psram_phase_fsm #(
      .CNT_W    (CNT_W),
      .ADDR_CYC (ADDR_CYC),
      .GAP_CYC  (GAP_CYC),
      .RD_CYC   (RD_CYC),
      .WR_CYC   (WR_CYC),
      .REC_CYC  (REC_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .is_write   (write_q),
      .dwell_done (dwell_done),
      .state      (state),
      .load       (load),
      .load_val   (load_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         write_q <= 1'b0;
      end else if (fire) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         be_q    <= req_be;
         write_q <= req_write;
      end
   end

   psram_lane_mask #(.LANES(LANES)) u_mask (
      .din     (psram_dq_i),
      .lane_en (be_q),
      .dout    (rd_masked)
   );

   assign rd_last = (state == ST_READ) && dwell_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_last;
         if (rd_last) rsp_rdata <= rd_masked;
      end
   end

   assign active       = (state == ST_ADDR) || (state == ST_HOLD) ||
                         (state == ST_READ) || (state == ST_WRITE);
   assign psram_cs_n   = ~active;
   assign psram_adv_n  = (state != ST_ADDR);
   assign psram_oe_n   = (state != ST_READ);
   assign psram_we_n   = (state != ST_WRITE);
   assign psram_bsel_n = active ? ~be_q : '1;
   assign psram_ahi    = addr_q[ADDR_W-1:DATA_W];
   assign psram_dq_oe  = (state == ST_ADDR) || (state == ST_HOLD) ||
                         (state == ST_WRITE);
   assign psram_dq_o   = (state == ST_WRITE) ? wdata_q : addr_q[DATA_W-1:0];
endmodule

// File: rtl/psram_mux_ctrl_chk.sv
module psram_mux_ctrl_chk #(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned PWRUP_CYC = 18750,
   parameter int unsigned WR_CYC    = 7,
   localparam int unsigned LANES    = DATA_W / 8,
   localparam int unsigned HI_W     = ADDR_W - DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              psram_cs_n,
   input logic              psram_adv_n,
   input logic              psram_oe_n,
   input logic              psram_we_n,
   input logic [LANES-1:0]  psram_bsel_n,
   input logic              psram_dq_oe
);
   localparam int unsigned PW = $clog2(PWRUP_CYC + 1);
   localparam int unsigned WW = $clog2(WR_CYC + 2);

   logic [PW-1:0] pwr_cnt;
   logic [WW-1:0] we_lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pwr_cnt <= '0;
      else if (pwr_cnt != PW'(PWRUP_CYC)) pwr_cnt <= pwr_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           we_lo_cnt <= '0;
      else if (psram_we_n)  we_lo_cnt <= '0;
      else if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
   end

   // R1
   pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_cnt < PW'(PWRUP_CYC)) |-> (psram_cs_n && !req_ready));

   // R2
   adv_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psram_adv_n |-> (!psram_cs_n && psram_dq_oe));

   // R3
   oe_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psram_oe_n) |-> (psram_adv_n && $past(psram_adv_n)));

   // R3
   we_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psram_we_n) |-> (psram_adv_n && $past(psram_adv_n)));

   // R4
   oe_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psram_oe_n |-> (!psram_dq_oe && psram_we_n && !psram_cs_n));

   // R5
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6
   we_max_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_lo_cnt <= WW'(WR_CYC));

   // R6
   we_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psram_we_n |-> (psram_dq_oe && !psram_cs_n));

   // R7
   bsel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!psram_cs_n && $past(!psram_cs_n)) |-> $stable(psram_bsel_n));

   // R7
   bsel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psram_cs_n |-> (psram_bsel_n == '1));

   // R8
   cs_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(psram_cs_n) |=> psram_cs_n);

   // R8
   ready_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> psram_cs_n);
endmodule

bind psram_mux_ctrl psram_mux_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PWRUP_CYC (PWRUP_CYC),
   .WR_CYC    (WR_CYC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_ready    (req_ready),
   .rsp_valid    (rsp_valid),
   .psram_cs_n   (psram_cs_n),
   .psram_adv_n  (psram_adv_n),
   .psram_oe_n   (psram_oe_n),
   .psram_we_n   (psram_we_n),
   .psram_bsel_n (psram_bsel_n),
   .psram_dq_oe  (psram_dq_oe)
);

// File: tb/tb_psram_mux_ctrl.sv
module tb_psram_mux_ctrl;
   localparam int unsigned PWRUP_CYC = 18750;
   localparam int unsigned ADDR_CYC  = 1;
   localparam int unsigned GAP_CYC   = 1;
   localparam int unsigned RD_CYC    = 9;
   localparam int unsigned WR_CYC    = 7;
   localparam int unsigned REC_CYC   = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic        cs_n, adv_n, oe_n, we_n, dq_oe;
   logic [1:0]  bsel_n;
   logic [4:0]  ahi;
   logic [15:0] dq_o, dq_i;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   psram_mux_ctrl #(
      .PWRUP_CYC (PWRUP_CYC), .ADDR_CYC (ADDR_CYC), .GAP_CYC (GAP_CYC),
      .RD_CYC (RD_CYC), .WR_CYC (WR_CYC), .REC_CYC (REC_CYC)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
      .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
      .psram_cs_n (cs_n), .psram_adv_n (adv_n), .psram_oe_n (oe_n),
      .psram_we_n (we_n), .psram_bsel_n (bsel_n), .psram_ahi (ahi),
      .psram_dq_o (dq_o), .psram_dq_oe (dq_oe), .psram_dq_i (dq_i)
   );

   // memory model: 64 words indexed by low address bits
   logic [15:0] mem [64];
   logic [20:0] lat_addr = '0;
   logic        p_we = 1'b1;
   logic [15:0] p_dq = '0;
   logic [1:0]  p_bsel = 2'b11;

   initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

   always @(negedge clk) begin
      if (!adv_n && !cs_n) lat_addr <= {ahi, dq_o};
      if (!p_we && we_n) begin
         if (!p_bsel[1]) mem[lat_addr[5:0]][15:8] <= p_dq[15:8];
         if (!p_bsel[0]) mem[lat_addr[5:0]][7:0]  <= p_dq[7:0];
      end
      p_we   <= we_n;
      p_dq   <= dq_o;
      p_bsel <= bsel_n;
   end

   always_comb begin
      if (!cs_n && !oe_n) begin
         dq_i[15:8] = bsel_n[1] ? 8'hA5 : mem[lat_addr[5:0]][15:8];
         dq_i[7:0]  = bsel_n[0] ? 8'h5A : mem[lat_addr[5:0]][7:0];
      end else begin
         dq_i = 16'hC3C3;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one access with pin-level timing observation
   task automatic access(input bit wr, input logic [20:0] a, input logic [15:0] wd,
                         input logic [1:0] be, input logic [15:0] exp_rd);
      int adv_c = 0, gap_c = 0, oe_c = 0, we_c = 0, rec_c = 0;
      bit addr_ok = 1, gap_ok = 1, oe_ok = 1, we_ok = 1, bs_ok = 1, rdy_ok = 1;
      bit order_ok = 1;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      while (!cs_n) begin
         if (bsel_n != ~be) bs_ok = 0;
         if (req_ready) rdy_ok = 0;
         if (!adv_n) begin
            adv_c++;
            if (!dq_oe || dq_o != a[15:0] || ahi != a[20:16] || !oe_n || !we_n) addr_ok = 0;
         end else if (!oe_n) begin
            oe_c++;
            if (dq_oe || !we_n) oe_ok = 0;
         end else if (!we_n) begin
            we_c++;
            if (!dq_oe || dq_o != wd) we_ok = 0;
         end else begin
            gap_c++;
            if (!dq_oe || dq_o != a[15:0] || oe_c != 0 || we_c != 0) gap_ok = 0;
            if (adv_c == 0) order_ok = 0;
         end
         @(negedge clk);
      end
      // first cycle with chip select high
      if (!wr) begin
         chk(rsp_valid === 1'b1, "R5", "rsp_valid after read", rsp_valid, 1);
         chk(rsp_rdata === exp_rd, "R5", "read data", rsp_rdata, exp_rd);
      end else begin
         chk(rsp_valid === 1'b0, "R5", "no rsp after write", rsp_valid, 0);
         chk(we_n === 1'b1, "R6", "we rises with cs", we_n, 1);
      end
      chk(bsel_n === 2'b11, "R7", "bsel idle", bsel_n, 2'b11);
      while (!req_ready) begin
         if (!cs_n) rdy_ok = 0;
         rec_c++;
         @(negedge clk);
         if (rec_c == 1 && !wr)
            chk(rsp_valid === 1'b0, "R5", "rsp one cycle", rsp_valid, 0);
      end
      chk(adv_c == ADDR_CYC && addr_ok, "R2", "address phase", adv_c, ADDR_CYC);
      chk(gap_c == GAP_CYC && gap_ok && order_ok, "R3", "hold gap", gap_c, GAP_CYC);
      if (wr) begin
         chk(we_c == WR_CYC && we_ok && oe_c == 0, "R6", "write pulse", we_c, WR_CYC);
      end else begin
         chk(oe_c == RD_CYC && oe_ok && we_c == 0, "R4", "read window", oe_c, RD_CYC);
      end
      chk(bs_ok, "R7", "byte selects", bsel_n, ~be);
      chk(rec_c >= REC_CYC && rdy_ok, "R8", "recovery", rec_c, REC_CYC);
   endtask

   task automatic t_reset();
      int n = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cs_n && adv_n && oe_n && we_n && bsel_n == 2'b11 && !dq_oe, "R1",
          "reset pins", {cs_n, adv_n, oe_n, we_n, bsel_n, dq_oe}, 7'b1111110);
      chk(req_ready === 1'b0, "R1", "ready in reset", req_ready, 0);
      rst_n = 1'b1;
      do begin
         @(negedge clk);
         n++;
         if (!cs_n) begin
            chk(0, "R1", "cs during power-up", cs_n, 1);
            break;
         end
      end while (!req_ready && n < PWRUP_CYC + 10);
      chk(n == PWRUP_CYC, "R1", "power-up length", n, PWRUP_CYC);
   endtask

   task automatic t_word();
      access(1'b1, 21'h1A0C5, 16'hBEEF, 2'b11, 16'h0);
      access(1'b0, 21'h1A0C5, 16'h0, 2'b11, 16'hBEEF);
   endtask

   task automatic t_bytes();
      access(1'b1, 21'h00007, 16'h1122, 2'b11, 16'h0);
      access(1'b1, 21'h00007, 16'h33EE, 2'b10, 16'h0);   // R9 upper lane only
      access(1'b0, 21'h00007, 16'h0, 2'b01, 16'h0022);   // R5 upper lane masked
      access(1'b0, 21'h00007, 16'h0, 2'b11, 16'h3322);   // R9 merged word
      access(1'b1, 21'h00007, 16'hDD44, 2'b01, 16'h0);   // R9 lower lane only
      access(1'b0, 21'h00007, 16'h0, 2'b10, 16'h3300);
      access(1'b0, 21'h00007, 16'h0, 2'b11, 16'h3344);
   endtask

   task automatic t_high_addr();
      access(1'b1, 21'h1FFFFF, 16'h0F0F, 2'b11, 16'h0);
      access(1'b0, 21'h1FFFFF, 16'h0, 2'b11, 16'h0F0F);
      access(1'b0, 21'h10000, 16'h0, 2'b11, 16'h0000);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_word();
      t_bytes();
      t_high_addr();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=expired expected=done");
      summary();
   end
endmodule